// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This block is a memory-mapped real-time clock. It holds a 32-bit count of seconds, and the count moves up by one on each one-second tick. In the default build the tick comes in as an enable pulse on `tickIn`. When `USE_PRESCALER` is set, an internal divider makes the tick instead, and `tickIn` then acts as the base-rate enable for that divider. Software sets the count by writing a load register. It programs a 32-bit match value and sets a one-bit interrupt mask. When a tick brings the count onto the match value, a sticky status bit goes high. The interrupt line is that status bit gated by the mask.

The register window is 4 KB and is word addressed. A request is presented for one cycle with `reqValid`. The read data and the error flag come back on the following cycle. The top of the window holds eight read-only identification bytes. The control word always reads as enabled. Accesses to offsets that are not decoded raise the error flag and change nothing.

Top module: `secrtc_top`

## Requirements
- R1: After reset the count, match, load and mask registers and the raw status all read zero. `irq` and `rspErr` are low.
- R2: A request with `reqValid` high returns its read data on `rspData` one cycle later, and `rspData` is zero for any cycle that does not answer a good read. The read offsets are: 0x00 returns the current count (its value before that cycle's update), 0x04 returns the match value, 0x08 returns the last load value, and 0x10 returns the mask in bit 0. Offsets 0x04, 0x08 and 0x10 are writable.
- R3: A write to 0x08 sets the count to the written value, and later ticks count on from that value. If the write and a tick fall in the same cycle, the written value wins and that tick is lost.
- R4: Each tick adds exactly one to the count, and 0xFFFFFFFF rolls over to 0. Without a tick or a load the count holds.
- R5: Raw status is set in the cycle where a tick brings the count equal to the match value. This includes a match value that is only reached after the count rolls over. A load that writes the match value does not set it. The bit stays set until a write to 0x1C with bit 0 at 1, and a write with bit 0 at 0 leaves it alone. A set and a clear in the same cycle leave the bit set.
- R6: `irq` and bit 0 of a read of 0x18 both equal raw status AND mask. A read of 0x14 returns raw status in bit 0.
- R7: A read of 0x0C always returns 1, and writes to 0x0C have no effect.
- R8: Reads of 0xFE0 to 0xFFC return one identification byte each, zero-extended, in this word order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Writes to 0x00, 0x14, 0x18, 0x0C and the identification words change no state and raise no error.
- R10: A read of 0x1C, any offset that is not decoded, and any offset with address bits [1:0] not zero all give `rspErr` high for exactly the one response cycle, with zero read data and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-second tick, or the divider enable when the prescaler is built in |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset within the window |
| reqWdata | input | 32 | Write data |
| rspData | output | 32 | Read data, one cycle after the request |
| rspErr | output | 1 | Access error, one cycle after the request |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
Every register update takes effect at the clock edge that ends the request or tick cycle. So `rspErr`, `rspData` and the new `irq` level all appear one cycle after the stimulus, and a read always returns the state from before that same edge. The bench drives each stimulus on the falling edge and waits through exactly one rising edge. It then applies the requirement-level model to the state from before the edge and compares all three outputs on the next falling edge. In this way a count read, a load, and a match hit landing in the same cycle are each checked against the right edge.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  typedef enum logic [3:0] {
    RD_COUNT, RD_MATCH, RD_LOAD, RD_CTRL,
    RD_MASK, RD_RAW, RD_MASKED, RD_IDENT
  } rdSel_e;

  typedef struct packed {
    logic   ldMatch;
    logic   ldLoad;
    logic   ldMask;
    logic   clrRaw;
    logic   rdEn;
    rdSel_e rdSel;
    logic [2:0] idIdx;
  } strobe_t;

  function automatic logic [7:0] identByte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/secrtc_prescale.sv
module secrtc_prescale #(
  parameter int DIV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic baseEn,
  output logic tickOut
);
  localparam int CNT_W = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_CYCLES - 1);

  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickOut <= 1'b0;
    end else begin
      tickOut <= 1'b0;
      if (baseEn) begin
        if (divCnt == LAST) begin
          divCnt  <= '0;
          tickOut <= 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/secrtc_ctrl.sv
module secrtc_ctrl
  import secrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           stb,
  output logic              rspErr
);
  logic badAcc;
  logic lowWin;
  logic identWin;

  assign lowWin   = (reqAddr[ADDR_W-1:5] == '0);
  assign identWin = (reqAddr[ADDR_W-1:5] == '1);

  always_comb begin
    stb    = '0;
    badAcc = 1'b0;
    if (reqValid) begin
      if (reqAddr[1:0] != 2'b00) begin
        badAcc = 1'b1;
      end else if (lowWin) begin
        case (reqAddr[4:2])
          3'd0: if (!reqWrite) begin stb.rdEn = 1'b1; stb.rdSel = RD_COUNT; end
          3'd1: if (reqWrite) stb.ldMatch = 1'b1;
                else begin stb.rdEn = 1'b1; stb.rdSel = RD_MATCH; end
          3'd2: if (reqWrite) stb.ldLoad = 1'b1;
                else begin stb.rdEn = 1'b1; stb.rdSel = RD_LOAD; end
          3'd3: if (!reqWrite) begin stb.rdEn = 1'b1; stb.rdSel = RD_CTRL; end
          3'd4: if (reqWrite) stb.ldMask = 1'b1;
                else begin stb.rdEn = 1'b1; stb.rdSel = RD_MASK; end
          3'd5: if (!reqWrite) begin stb.rdEn = 1'b1; stb.rdSel = RD_RAW; end
          3'd6: if (!reqWrite) begin stb.rdEn = 1'b1; stb.rdSel = RD_MASKED; end
          default: if (reqWrite) stb.clrRaw = 1'b1;
                   else badAcc = 1'b1;
        endcase
      end else if (identWin) begin
        if (!reqWrite) begin
          stb.rdEn  = 1'b1;
          stb.rdSel = RD_IDENT;
          stb.idIdx = reqAddr[4:2];
        end
      end else begin
        badAcc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspErr <= 1'b0;
    else       rspErr <= badAcc;
  end
endmodule

// File: rtl/secrtc_dp.sv
module secrtc_dp
  import secrtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rspData,
  output logic              irq,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] matchVal,
  output logic              rawStat,
  output logic              maskBit
);
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] nextCount;
  logic [DATA_W-1:0] rdMux;
  logic              hit;

  assign nextCount = countVal + 1'b1;
  assign hit       = tick && !stb.ldLoad && (nextCount == matchVal);
  assign irq       = rawStat & maskBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      matchVal <= '0;
      loadVal  <= '0;
      maskBit  <= 1'b0;
      rawStat  <= 1'b0;
    end else begin
      if (stb.ldLoad) begin
        countVal <= wdata;
        loadVal  <= wdata;
      end else if (tick) begin
        countVal <= nextCount;
      end
      if (stb.ldMatch) matchVal <= wdata;
      if (stb.ldMask)  maskBit  <= wdata[0];
      if (hit)                         rawStat <= 1'b1;
      else if (stb.clrRaw && wdata[0]) rawStat <= 1'b0;
    end
  end

  always_comb begin
    rdMux = '0;
    case (stb.rdSel)
      RD_COUNT:  rdMux = countVal;
      RD_MATCH:  rdMux = matchVal;
      RD_LOAD:   rdMux = loadVal;
      RD_CTRL:   rdMux = DATA_W'(1);
      RD_MASK:   rdMux = DATA_W'(maskBit);
      RD_RAW:    rdMux = DATA_W'(rawStat);
      RD_MASKED: rdMux = DATA_W'(irq);
      RD_IDENT:  rdMux = DATA_W'(identByte(stb.idIdx));
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rspData <= '0;
    else if (stb.rdEn)  rspData <= rdMux;
    else                rspData <= '0;
  end
endmodule

// File: rtl/secrtc_top.sv
module secrtc_top
  import secrtc_pkg::*;
#(
  parameter bit USE_PRESCALER = 1'b0,
  parameter int DIV_CYCLES    = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              irq
);
  strobe_t           stb;
  logic              tick;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] matchVal;
  logic              rawStat;
  logic              maskBit;

  generate
    if (USE_PRESCALER) begin : g_div
      secrtc_prescale #(.DIV_CYCLES(DIV_CYCLES)) u_div (
        .clk(clk), .rstN(rstN), .baseEn(tickIn), .tickOut(tick)
      );
    end else begin : g_ext
      assign tick = tickIn;
    end
  endgenerate

  secrtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .stb(stb), .rspErr(rspErr)
  );

  secrtc_dp u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .wdata(reqWdata),
    .rspData(rspData), .irq(irq), .countVal(countVal), .matchVal(matchVal),
    .rawStat(rawStat), .maskBit(maskBit)
  );
endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tick,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [11:0] reqAddr,
  input logic [31:0] reqWdata,
  input logic [31:0] rspData,
  input logic        rspErr,
  input logic        irq,
  input logic [31:0] countVal,
  input logic [31:0] matchVal,
  input logic        rawStat
);
  logic loadWr, clrWr, rdMasked, rdCtrl, rdClr;
  assign loadWr   = reqValid && reqWrite && (reqAddr == 12'h008);
  assign clrWr    = reqValid && reqWrite && (reqAddr == 12'h01C) && reqWdata[0];
  assign rdMasked = reqValid && !reqWrite && (reqAddr == 12'h018);
  assign rdCtrl   = reqValid && !reqWrite && (reqAddr == 12'h00C);
  assign rdClr    = reqValid && !reqWrite && (reqAddr == 12'h01C);

  p_load_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && loadWr) |-> countVal == $past(reqWdata));

  p_tick_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && tick && !loadWr) |-> countVal == $past(countVal) + 32'd1);

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !tick && !loadWr) |-> countVal == $past(countVal));

  p_raw_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && tick && !loadWr && (countVal + 32'd1 == matchVal)) |-> rawStat);

  p_raw_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && rawStat && !clrWr) |-> rawStat);

  p_masked_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && rdMasked) |-> rspData == {31'd0, $past(irq)});

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && rdCtrl) |-> rspData == 32'd1);

  p_clr_read_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && rdClr) |-> (rspErr && rspData == 32'd0));
endmodule

bind secrtc_top secrtc_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .reqValid(reqValid),
  .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
  .rspData(rspData), .rspErr(rspErr), .irq(irq),
  .countVal(countVal), .matchVal(matchVal), .rawStat(rawStat)
);

// File: tb/sim_secrtc_top.sv
module sim_secrtc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rspData;
  logic        rspErr;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  // spec model state
  logic [31:0] mCount = '0, mMatch = '0, mLoad = '0;
  logic        mMask = 1'b0, mRaw = 1'b0;

  always #2 clk = ~clk;

  secrtc_top u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspData(rspData), .rspErr(rspErr), .irq(irq)
  );

  function automatic logic [7:0] idExp(input int i);
    case (i)
      0: return 8'h31; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic bit isIdent(input logic [11:0] a);
    return (a >= 12'hFE0) && (a[1:0] == 2'b00);
  endfunction

  function automatic bit errExp(input logic v, input logic w, input logic [11:0] a);
    if (!v) return 1'b0;
    if (a[1:0] != 2'b00) return 1'b1;
    if (isIdent(a)) return 1'b0;
    if (a > 12'h01C) return 1'b1;
    return (a == 12'h01C) && !w;
  endfunction

  function automatic logic [31:0] readExp(input logic v, input logic w, input logic [11:0] a);
    if (!v || w || errExp(v, w, a)) return 32'd0;
    if (isIdent(a)) return {24'd0, idExp(int'(a[4:2]))};
    case (a)
      12'h000: return mCount;
      12'h004: return mMatch;
      12'h008: return mLoad;
      12'h00C: return 32'd1;
      12'h010: return {31'd0, mMask};
      12'h014: return {31'd0, mRaw};
      12'h018: return {31'd0, mRaw & mMask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic v, input logic w, input logic [11:0] a);
    if (!v) return "R4";
    if (errExp(v, w, a)) return "R10";
    if (isIdent(a)) return w ? "R9" : "R8";
    case (a)
      12'h008: return "R3";
      12'h00C: return "R7";
      12'h014, 12'h018: return w ? "R9" : "R6";
      12'h01C: return "R5";
      12'h000: return w ? "R9" : "R2";
      default: return "R2";
    endcase
  endfunction

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic v, input logic w, input logic [11:0] a,
                      input logic [31:0] d, input logic t, input string tagIn);
    logic [31:0] eData;
    logic        eErr;
    logic        ldW, clrW, setR;
    string       tag;
    tag = (tagIn == "") ? tagFor(v, w, a) : tagIn;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d; tickIn = t;
    @(posedge clk);
    eData = readExp(v, w, a);
    eErr  = errExp(v, w, a);
    ldW   = v && w && (a == 12'h008);
    clrW  = v && w && (a == 12'h01C) && d[0];
    setR  = t && !ldW && (mCount + 32'd1 == mMatch);
    if (ldW) begin mCount = d; mLoad = d; end
    else if (t) mCount = mCount + 32'd1;
    if (v && w && a == 12'h004) mMatch = d;
    if (v && w && a == 12'h010) mMask = d[0];
    if (setR) mRaw = 1'b1;
    else if (clrW) mRaw = 1'b0;
    @(negedge clk);
    check32(tag, "rspData", rspData, eData);
    check32(eErr ? "R10" : tag, "rspErr", {31'd0, rspErr}, {31'd0, eErr});
    check32("R6", "irq", {31'd0, irq}, {31'd0, mRaw & mMask});
    reqValid = 1'b0; reqWrite = 1'b0; tickIn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check32("R1", "irq after reset", {31'd0, irq}, 32'd0);
    check32("R1", "rspErr after reset", {31'd0, rspErr}, 32'd0);
    rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h008, "R1");
    rd(12'h010, "R1"); rd(12'h014, "R1");
    // R8 identification bytes
    for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i), "R8");
    // R7 control ignores writes
    wr(12'h00C, 32'h0, "R7"); rd(12'h00C, "R7");
    // R3 / R4 / R5 wrap-around match
    wr(12'h010, 32'h1, "R6");
    wr(12'h008, 32'hFFFF_FFFE, "R3");
    wr(12'h004, 32'h0000_0001, "R5");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 12'h0, 32'd0, 1'b1, "R4");
    rd(12'h000, "R4"); rd(12'h014, "R5"); rd(12'h018, "R6");
    // R5 write 0 keeps, write 1 clears
    wr(12'h01C, 32'h0, "R5"); rd(12'h014, "R5");
    wr(12'h01C, 32'h1, "R5"); rd(12'h014, "R5");
    // R5 load onto match value does not set status
    wr(12'h008, 32'h0000_0001, "R5"); rd(12'h014, "R5");
    // R3 load and tick in same cycle: load wins
    step(1'b1, 1'b1, 12'h008, 32'h0000_0100, 1'b1, "R3"); rd(12'h000, "R3");
    // R5 set and clear in same cycle: set wins
    wr(12'h004, 32'h0000_0101, "R5");
    step(1'b1, 1'b1, 12'h01C, 32'h1, 1'b1, "R5"); rd(12'h014, "R5");
    // R9 writes to read-only words ignored
    wr(12'h000, 32'hDEAD_BEEF, "R9"); wr(12'h014, 32'h0, "R9");
    wr(12'h018, 32'h0, "R9"); wr(12'hFE4, 32'h55, "R9");
    rd(12'h000, "R9"); rd(12'h014, "R9"); rd(12'hFE4, "R9");
    // R10 error accesses
    rd(12'h01C, "R10"); rd(12'h020, "R10"); wr(12'h400, 32'h1, "R10");
    wr(12'h009, 32'h1234, "R10"); rd(12'h000, "R10");
    // random mix
    for (int n = 0; n < 2500; n++) begin
      int          sel;
      logic [11:0] a;
      logic [31:0] d;
      logic        w;
      sel = int'($urandom % 12);
      w   = ($urandom % 2) == 0;
      d   = $urandom;
      if (sel < 8) a = 12'(sel * 4);
      else if (sel == 8) a = 12'hFE0 + 12'(4 * ($urandom % 8));
      else if (sel == 9) a = 12'h020 + 12'(4 * ($urandom % 12'h3E0));
      else if (sel == 10) a = 12'(($urandom % 12'h400) * 4) | 12'(1 + $urandom % 3);
      else a = 12'h008;
      if (a == 12'h004) d = mCount + 32'($urandom % 4);
      if (a == 12'h008 && ($urandom % 2) == 0) d = 32'hFFFF_FFFF - 32'($urandom % 3);
      step(($urandom % 4) != 0, w, a, d, ($urandom % 10) < 4, "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule